// File: doc/BRIEF.md
# Single-Cycle Stack-Aware Processor Control Unit

This block is the purely combinational steering logic of a processor that completes one instruction per clock. It receives the decoded fields of the current instruction: a 4-bit instruction code, a 4-bit function code, two 4-bit register IDs and a constant word. It also receives the values produced around it: the sequential next PC, two register-file read values, the ALU result, the memory read value and the branch decision. From these it produces the register-file read and write addresses, the two ALU operands, the ALU function, the condition-code load strobe, the data-memory controls and the PC for the next cycle. The register file, the ALU, the condition-code register and both memories are outside the block.

The stack instructions (push, pop, call and return) do their stack-pointer arithmetic on the same ALU, using a constant of plus or minus the word step as the first operand. Pop writes two registers in the same cycle: the stack pointer through the E port and the popped value through the M port. Register ID 4 is the stack pointer. Register ID 8 means "no register", and the register file performs no access on that ID.

Instruction codes: 0 idle, 1 stop, 2 register move, 3 immediate load, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 (hex A) push, 11 (hex B) pop. Codes 12 to 15 are not defined.

Top module: `stack_cpu_ctrl`

## Requirements
- R1: The read address A (`rd_addr_a`) is `ra_id` for codes 2, 4, 6 and 10. It is 4 for codes 9 and 11. It is 8 for every other code.
- R2: The read address B (`rd_addr_b`) is `rb_id` for codes 4, 5 and 6. It is 4 for codes 8, 9, 10 and 11. It is 8 otherwise.
- R3: The E write address (`wr_addr_e`) is `rb_id` for codes 2, 3 and 6. It is 4 for codes 8, 9, 10 and 11. It is 8 otherwise.
- R4: The M write address (`wr_addr_m`) is `ra_id` for codes 5 and 11, and 8 otherwise. For code 11 with `ra_id` = 4, both write addresses are 4.
- R5: ALU operand A (`alu_in_a`) is `reg_a_val` for codes 2 and 6. It is `const_word` for codes 3, 4 and 5. It is the two's-complement of 4 (0xFFFFFFFC) for codes 8 and 10. It is +4 for codes 9 and 11. It is zero otherwise.
- R6: ALU operand B (`alu_in_b`) is zero for codes 2 and 3, and `reg_b_val` for every other code.
- R7: For code 6, `alu_fn` equals `fn_code` and `cc_load` is 1. For every other code, `alu_fn` is 0 (add) and `cc_load` is 0.
- R8: `mem_rd_en` is 1 only for codes 5, 9 and 11. `mem_wr_en` is 1 only for codes 4, 8 and 10. The two are never 1 together.
- R9: `mem_addr` is `alu_result` for codes 4, 5, 8 and 10, `reg_a_val` for codes 9 and 11, and zero otherwise. `mem_wdata` is `seq_pc` for code 8 and `reg_a_val` for every other code.
- R10: `next_pc` is `const_word` for code 8. It is `const_word` for code 7 when `take_branch` is 1. It is `mem_rd_val` for code 9. It is `seq_pc` in all other cases, including code 7 with `take_branch` = 0.
- R11: Codes 0, 1 and 12 to 15 have no effect at the outputs. All four register addresses are 8, there is no memory access, `cc_load` is 0, and `next_pc` is `seq_pc`. For these codes, and for every code that does not use it, `take_branch` does not change `next_pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_code | input | 4 | Instruction code |
| fn_code | input | 4 | Function code |
| ra_id | input | 4 | First register field |
| rb_id | input | 4 | Second register field |
| const_word | input | 32 | Instruction constant |
| seq_pc | input | 32 | Address of the following instruction |
| reg_a_val | input | 32 | Register file read value A |
| reg_b_val | input | 32 | Register file read value B |
| alu_result | input | 32 | ALU output |
| mem_rd_val | input | 32 | Data memory read value |
| take_branch | input | 1 | Branch condition result |
| rd_addr_a | output | 4 | Register read address A |
| rd_addr_b | output | 4 | Register read address B |
| wr_addr_e | output | 4 | Register write address, ALU port |
| wr_addr_m | output | 4 | Register write address, memory port |
| alu_in_a | output | 32 | ALU operand A |
| alu_in_b | output | 32 | ALU operand B |
| alu_fn | output | 4 | ALU function, 0 = add |
| cc_load | output | 1 | Load condition codes |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_addr | output | 32 | Data memory address |
| mem_wdata | output | 32 | Data memory write data |
| next_pc | output | 32 | PC for the next cycle |

## Verification
Two duties meet in one cycle in two places. Pop drives both register write ports at once, and call both stores the return address and redirects the PC. The bench provokes the first with pop using several destination fields, including the stack pointer itself, and checks that the E address is 4 and the M address is the named register. It provokes the second by giving call distinct constant, sequential-PC and ALU-result values, then confirms that the write data is the sequential PC, the address is the ALU result and the next PC is the constant, whatever the branch input holds.

// File: rtl/sc_pkg.sv
// Shared definitions for the single-cycle control unit.
// Assumes 4-bit instruction codes. The values are fixed because the fetch
// stage and the assembler decode the same codes.
package sc_pkg;

    localparam logic [3:0] IC_IDLE  = 4'h0;
    localparam logic [3:0] IC_STOP  = 4'h1;
    localparam logic [3:0] IC_MOVRR = 4'h2;
    localparam logic [3:0] IC_MOVIR = 4'h3;
    localparam logic [3:0] IC_STORE = 4'h4;
    localparam logic [3:0] IC_LOAD  = 4'h5;
    localparam logic [3:0] IC_ARITH = 4'h6;
    localparam logic [3:0] IC_JUMP  = 4'h7;
    localparam logic [3:0] IC_CALL  = 4'h8;
    localparam logic [3:0] IC_RET   = 4'h9;
    localparam logic [3:0] IC_PUSH  = 4'hA;
    localparam logic [3:0] IC_POP   = 4'hB;

    // One flag per recognised instruction; at most one is set.
    typedef struct packed {
        logic movrr;
        logic movir;
        logic store;
        logic load;
        logic arith;
        logic jump;
        logic call;
        logic ret;
        logic push;
        logic pop;
    } insn_cls_t;

endpackage

// File: rtl/sc_insn_class.sv
// Instruction classifier: turns the instruction code into one-hot class flags.
// Assumes nothing about the function code. Idle, stop and undefined codes
// give an all-zero class, and every consumer treats that as "no effect".
module sc_insn_class
    import sc_pkg::*;
(
    input  logic [3:0] code_in,
    output insn_cls_t  cls_out
);

    // Decode the instruction code into class flags.
    always_comb begin
        cls_out = '0;
        case (code_in)
            IC_MOVRR: cls_out.movrr = 1'b1;
            IC_MOVIR: cls_out.movir = 1'b1;
            IC_STORE: cls_out.store = 1'b1;
            IC_LOAD:  cls_out.load  = 1'b1;
            IC_ARITH: cls_out.arith = 1'b1;
            IC_JUMP:  cls_out.jump  = 1'b1;
            IC_CALL:  cls_out.call  = 1'b1;
            IC_RET:   cls_out.ret   = 1'b1;
            IC_PUSH:  cls_out.push  = 1'b1;
            IC_POP:   cls_out.pop   = 1'b1;
            default:  cls_out = '0;
        endcase
    end

endmodule

// File: rtl/sc_reg_ports.sv
// Register-file port steering: picks the two read IDs and the two write IDs.
// Assumes the register file ignores NO_REG on any port. Pop uses both
// write ports at once (stack pointer on E, loaded value on M).
module sc_reg_ports
    import sc_pkg::*;
#(
    parameter int RID_W  = 4,
    parameter int SP_ID  = 4,
    parameter int NO_REG = 8
) (
    input  insn_cls_t        cls,
    input  logic [RID_W-1:0] ra_fld,
    input  logic [RID_W-1:0] rb_fld,
    output logic [RID_W-1:0] src_a,
    output logic [RID_W-1:0] src_b,
    output logic [RID_W-1:0] dst_e,
    output logic [RID_W-1:0] dst_m
);

    localparam logic [RID_W-1:0] SP_V   = RID_W'(SP_ID);
    localparam logic [RID_W-1:0] NONE_V = RID_W'(NO_REG);

    logic stack_user;

    // Instructions that read and update the stack pointer.
    always_comb stack_user = cls.call | cls.ret | cls.push | cls.pop;

    // Read port A: first field, stack pointer, or none.
    always_comb begin
        if (cls.movrr | cls.store | cls.arith | cls.push)
            src_a = ra_fld;
        else if (cls.ret | cls.pop)
            src_a = SP_V;
        else
            src_a = NONE_V;
    end

    // Read port B: second field, stack pointer, or none.
    always_comb begin
        if (cls.arith | cls.store | cls.load)
            src_b = rb_fld;
        else if (stack_user)
            src_b = SP_V;
        else
            src_b = NONE_V;
    end

    // Write port E: receives the ALU result.
    always_comb begin
        if (cls.movrr | cls.movir | cls.arith)
            dst_e = rb_fld;
        else if (stack_user)
            dst_e = SP_V;
        else
            dst_e = NONE_V;
    end

    // Write port M: receives the memory read value.
    always_comb begin
        if (cls.load | cls.pop)
            dst_m = ra_fld;
        else
            dst_m = NONE_V;
    end

endmodule

// File: rtl/sc_exec_ctrl.sv
// Execute-stage steering: ALU operands, ALU function and condition-code load.
// Assumes the ALU treats function 0 as add. Stack instructions add a signed
// step constant to the stack pointer arriving on operand B.
module sc_exec_ctrl
    import sc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FN_W   = 4,
    parameter int STEP   = 4
) (
    input  insn_cls_t         cls,
    input  logic [FN_W-1:0]   fn_fld,
    input  logic [WORD_W-1:0] cval,
    input  logic [WORD_W-1:0] aval,
    input  logic [WORD_W-1:0] bval,
    output logic [WORD_W-1:0] opnd_a,
    output logic [WORD_W-1:0] opnd_b,
    output logic [FN_W-1:0]   fn_sel,
    output logic              cc_en
);

    localparam logic [WORD_W-1:0] STEP_UP = WORD_W'(STEP);
    localparam logic [WORD_W-1:0] STEP_DN = {WORD_W{1'b0}} - STEP_UP;

    // Operand A: register value, constant, or stack step.
    always_comb begin
        if (cls.movrr | cls.arith)
            opnd_a = aval;
        else if (cls.movir | cls.store | cls.load)
            opnd_a = cval;
        else if (cls.call | cls.push)
            opnd_a = STEP_DN;
        else if (cls.ret | cls.pop)
            opnd_a = STEP_UP;
        else
            opnd_a = '0;
    end

    // Operand B: zero for the plain moves so that A passes through.
    always_comb opnd_b = (cls.movrr | cls.movir) ? '0 : bval;

    // The ALU function follows the code only for arithmetic; all others add.
    always_comb fn_sel = cls.arith ? fn_fld : '0;

    // Only arithmetic updates the condition codes.
    always_comb cc_en = cls.arith;

endmodule

// File: rtl/sc_flow_ctrl.sv
// Memory and PC steering: data-memory controls and the next-PC choice.
// Assumes a single data port, so a read and a write never share a cycle.
// The branch decision is only consulted for jumps.
module sc_flow_ctrl
    import sc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  insn_cls_t         cls,
    input  logic [WORD_W-1:0] cval,
    input  logic [WORD_W-1:0] pval,
    input  logic [WORD_W-1:0] aval,
    input  logic [WORD_W-1:0] eval_in,
    input  logic [WORD_W-1:0] mval,
    input  logic              br_ok,
    output logic              rd_en,
    output logic              wr_en,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] pc_nxt
);

    // Read for loads and stack pops (pop and return).
    always_comb rd_en = cls.load | cls.pop | cls.ret;

    // Write for stores and stack pushes (push and call).
    always_comb wr_en = cls.store | cls.push | cls.call;

    // Address: ALU result for computed or decremented addresses, old SP for pops.
    always_comb begin
        if (cls.store | cls.load | cls.push | cls.call)
            addr = eval_in;
        else if (cls.pop | cls.ret)
            addr = aval;
        else
            addr = '0;
    end

    // Write data: the return address for call, register A otherwise.
    always_comb wdata = cls.call ? pval : aval;

    // Next PC: target, return address, or the sequential address.
    always_comb begin
        if (cls.call || (cls.jump && br_ok))
            pc_nxt = cval;
        else if (cls.ret)
            pc_nxt = mval;
        else
            pc_nxt = pval;
    end

endmodule

// File: rtl/stack_cpu_ctrl.sv
// Top of the single-cycle control unit. It is purely combinational: the
// outputs follow the inputs within the same cycle. Assumes the fetch stage
// has already split the instruction into its fields. The register file,
// ALU, condition codes and memories sit outside.
module stack_cpu_ctrl
    import sc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RID_W  = 4,
    parameter int FN_W   = 4,
    parameter int SP_ID  = 4,
    parameter int NO_REG = 8,
    parameter int STEP   = 4
) (
    input  logic [3:0]        i_code,
    input  logic [FN_W-1:0]   fn_code,
    input  logic [RID_W-1:0]  ra_id,
    input  logic [RID_W-1:0]  rb_id,
    input  logic [WORD_W-1:0] const_word,
    input  logic [WORD_W-1:0] seq_pc,
    input  logic [WORD_W-1:0] reg_a_val,
    input  logic [WORD_W-1:0] reg_b_val,
    input  logic [WORD_W-1:0] alu_result,
    input  logic [WORD_W-1:0] mem_rd_val,
    input  logic              take_branch,
    output logic [RID_W-1:0]  rd_addr_a,
    output logic [RID_W-1:0]  rd_addr_b,
    output logic [RID_W-1:0]  wr_addr_e,
    output logic [RID_W-1:0]  wr_addr_m,
    output logic [WORD_W-1:0] alu_in_a,
    output logic [WORD_W-1:0] alu_in_b,
    output logic [FN_W-1:0]   alu_fn,
    output logic              cc_load,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] next_pc
);

    insn_cls_t cls;

    sc_insn_class u_class (
        .code_in (i_code),
        .cls_out (cls)
    );

    sc_reg_ports #(
        .RID_W  (RID_W),
        .SP_ID  (SP_ID),
        .NO_REG (NO_REG)
    ) u_regs (
        .cls    (cls),
        .ra_fld (ra_id),
        .rb_fld (rb_id),
        .src_a  (rd_addr_a),
        .src_b  (rd_addr_b),
        .dst_e  (wr_addr_e),
        .dst_m  (wr_addr_m)
    );

    sc_exec_ctrl #(
        .WORD_W (WORD_W),
        .FN_W   (FN_W),
        .STEP   (STEP)
    ) u_exec (
        .cls    (cls),
        .fn_fld (fn_code),
        .cval   (const_word),
        .aval   (reg_a_val),
        .bval   (reg_b_val),
        .opnd_a (alu_in_a),
        .opnd_b (alu_in_b),
        .fn_sel (alu_fn),
        .cc_en  (cc_load)
    );

    sc_flow_ctrl #(
        .WORD_W (WORD_W)
    ) u_flow (
        .cls     (cls),
        .cval    (const_word),
        .pval    (seq_pc),
        .aval    (reg_a_val),
        .eval_in (alu_result),
        .mval    (mem_rd_val),
        .br_ok   (take_branch),
        .rd_en   (mem_rd_en),
        .wr_en   (mem_wr_en),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .pc_nxt  (next_pc)
    );

endmodule

// File: rtl/stack_cpu_ctrl_chk.sv
// Checker for the control unit. The block has no clock, so each rule is an
// immediate check re-evaluated whenever its inputs settle. Each rule relates
// outputs that different submodules drive, or outputs to input fields.
module stack_cpu_ctrl_chk #(
    parameter int WORD_W = 32,
    parameter int RID_W  = 4,
    parameter int FN_W   = 4,
    parameter int SP_ID  = 4,
    parameter int NO_REG = 8
) (
    input logic [3:0]        i_code,
    input logic [FN_W-1:0]   fn_code,
    input logic [RID_W-1:0]  ra_id,
    input logic [WORD_W-1:0] const_word,
    input logic [WORD_W-1:0] seq_pc,
    input logic [RID_W-1:0]  rd_addr_a,
    input logic [RID_W-1:0]  wr_addr_e,
    input logic [RID_W-1:0]  wr_addr_m,
    input logic [FN_W-1:0]   alu_fn,
    input logic              cc_load,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] next_pc
);

    // Evaluate the rules on the settled outputs.
    always_comb begin
        p_stack_read_r1: assert (!(i_code == 4'h9 || i_code == 4'hB) || rd_addr_a == RID_W'(SP_ID))
            else $error("stack read address wrong");
        p_push_sp_write_r3: assert (!(mem_wr_en && i_code != 4'h4) || wr_addr_e == RID_W'(SP_ID))
            else $error("stack write without stack pointer update");
        p_mport_needs_read_r4: assert (wr_addr_m == RID_W'(NO_REG) || (mem_rd_en && wr_addr_m == ra_id))
            else $error("M port write without memory read");
        p_cc_fn_r7: assert (!cc_load || alu_fn == fn_code)
            else $error("condition load with wrong function");
        p_one_access_r8: assert (!(mem_rd_en && mem_wr_en))
            else $error("read and write together");
        p_call_data_r9: assert (!(mem_wr_en && i_code == 4'h8) || mem_wdata == seq_pc)
            else $error("call stores wrong data");
        p_call_target_r10: assert (i_code != 4'h8 || next_pc == const_word)
            else $error("call target wrong");
        p_idle_quiet_r11: assert (!(i_code < 4'h2 || i_code > 4'hB) ||
                                  (!mem_rd_en && !mem_wr_en && !cc_load && next_pc == seq_pc))
            else $error("undefined code had an effect");
    end

endmodule

bind stack_cpu_ctrl stack_cpu_ctrl_chk #(
    .WORD_W (WORD_W),
    .RID_W  (RID_W),
    .FN_W   (FN_W),
    .SP_ID  (SP_ID),
    .NO_REG (NO_REG)
) u_chk (
    .i_code     (i_code),
    .fn_code    (fn_code),
    .ra_id      (ra_id),
    .const_word (const_word),
    .seq_pc     (seq_pc),
    .rd_addr_a  (rd_addr_a),
    .wr_addr_e  (wr_addr_e),
    .wr_addr_m  (wr_addr_m),
    .alu_fn     (alu_fn),
    .cc_load    (cc_load),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_wdata  (mem_wdata),
    .next_pc    (next_pc)
);

// File: tb/sim_stack_cpu_ctrl.sv
// Scoreboard bench: the driver applies a vector just after a rising edge and
// queues the expected outputs; the monitor compares them on the falling edge.
module sim_stack_cpu_ctrl;

    typedef struct packed {
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic [3:0]  de;
        logic [3:0]  dm;
        logic [31:0] aa;
        logic [31:0] ab;
        logic [3:0]  fn;
        logic        cc;
        logic        rd;
        logic        wr;
        logic [31:0] ad;
        logic [31:0] wd;
        logic [31:0] np;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  i_code = '0, fn_code = '0, ra_id = '0, rb_id = '0;
    logic [31:0] const_word = '0, seq_pc = '0, reg_a_val = '0, reg_b_val = '0;
    logic [31:0] alu_result = '0, mem_rd_val = '0;
    logic        take_branch = 1'b0;
    logic [3:0]  rd_addr_a, rd_addr_b, wr_addr_e, wr_addr_m, alu_fn;
    logic [31:0] alu_in_a, alu_in_b, mem_addr, mem_wdata, next_pc;
    logic        cc_load, mem_rd_en, mem_wr_en;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];
    logic [31:0] seed = 32'h1357_9bdf;

    always #2 clk = ~clk;

    stack_cpu_ctrl u0 (.*);

    function automatic exp_t model(input logic [3:0] ic, input logic [3:0] f,
                                   input logic [3:0] ra, input logic [3:0] rb,
                                   input logic [31:0] c, input logic [31:0] p,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] e, input logic [31:0] m,
                                   input logic br);
        exp_t x;
        x.sa = 4'd8; x.sb = 4'd8; x.de = 4'd8; x.dm = 4'd8;
        x.aa = '0; x.ab = b; x.fn = '0; x.cc = 1'b0; x.rd = 1'b0; x.wr = 1'b0;
        x.ad = '0; x.wd = a; x.np = p;
        case (ic)
            4'h2: begin x.sa = ra; x.de = rb; x.aa = a; x.ab = '0; end
            4'h3: begin x.de = rb; x.aa = c; x.ab = '0; end
            4'h4: begin x.sa = ra; x.sb = rb; x.aa = c; x.wr = 1'b1; x.ad = e; end
            4'h5: begin x.sb = rb; x.dm = ra; x.aa = c; x.rd = 1'b1; x.ad = e; end
            4'h6: begin x.sa = ra; x.sb = rb; x.de = rb; x.aa = a; x.fn = f; x.cc = 1'b1; end
            4'h7: x.np = br ? c : p;
            4'h8: begin x.sb = 4'd4; x.de = 4'd4; x.aa = 32'hFFFF_FFFC; x.wr = 1'b1;
                        x.ad = e; x.wd = p; x.np = c; end
            4'h9: begin x.sa = 4'd4; x.sb = 4'd4; x.de = 4'd4; x.aa = 32'd4; x.rd = 1'b1;
                        x.ad = a; x.np = m; end
            4'hA: begin x.sa = ra; x.sb = 4'd4; x.de = 4'd4; x.aa = 32'hFFFF_FFFC;
                        x.wr = 1'b1; x.ad = e; end
            4'hB: begin x.sa = 4'd4; x.sb = 4'd4; x.de = 4'd4; x.dm = ra; x.aa = 32'd4;
                        x.rd = 1'b1; x.ad = a; end
            default: ;
        endcase
        return x;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    // Driver: apply one vector after a rising edge and queue its expectation.
    task automatic drive(input logic [3:0] ic, input logic [3:0] f, input logic [3:0] ra,
                         input logic [3:0] rb, input logic br);
        @(posedge clk);
        i_code = ic; fn_code = f; ra_id = ra; rb_id = rb; take_branch = br;
        const_word = rnd(); seq_pc = rnd(); reg_a_val = rnd(); reg_b_val = rnd();
        alu_result = rnd(); mem_rd_val = rnd();
        sb_q.push_back(model(ic, f, ra, rb, const_word, seq_pc, reg_a_val, reg_b_val,
                             alu_result, mem_rd_val, br));
    endtask

    // Monitor: compare the settled outputs against the oldest expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            chk("R1", "rd_addr_a", 32'(rd_addr_a), 32'(x.sa));
            chk("R2", "rd_addr_b", 32'(rd_addr_b), 32'(x.sb));
            chk("R3", "wr_addr_e", 32'(wr_addr_e), 32'(x.de));
            chk("R4", "wr_addr_m", 32'(wr_addr_m), 32'(x.dm));
            chk("R5", "alu_in_a", alu_in_a, x.aa);
            chk("R6", "alu_in_b", alu_in_b, x.ab);
            chk("R7", "alu_fn", 32'(alu_fn), 32'(x.fn));
            chk("R7", "cc_load", 32'(cc_load), 32'(x.cc));
            chk("R8", "mem_rd_en", 32'(mem_rd_en), 32'(x.rd));
            chk("R8", "mem_wr_en", 32'(mem_wr_en), 32'(x.wr));
            chk("R9", "mem_addr", mem_addr, x.ad);
            chk("R9", "mem_wdata", mem_wdata, x.wd);
            chk("R10", "next_pc", next_pc, x.np);
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: idle vectors while reset is held (R11).
        for (int k = 0; k < 3; k++) drive(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
        rst_n = 1'b1;
        // Full sweep of codes, functions and branch states (R1 to R11).
        for (int ic = 0; ic < 16; ic++)
            for (int f = 0; f < 4; f++)
                for (int br = 0; br < 2; br++)
                    drive(4'(ic), 4'(f), 4'(rnd() % 9), 4'(rnd() % 9), 1'(br));
        // Pop into the stack pointer: both write ports name 4 (R4).
        drive(4'hB, 4'h0, 4'd4, 4'd8, 1'b1);
        // Pop into another register while the branch input is high (R3, R4).
        drive(4'hB, 4'h0, 4'd6, 4'd8, 1'b1);
        // Call with branch low and high: target and stored return address (R9, R10).
        drive(4'h8, 4'h0, 4'd8, 4'd8, 1'b0);
        drive(4'h8, 4'h0, 4'd8, 4'd8, 1'b1);
        // Jump not taken and taken (R10).
        drive(4'h7, 4'h3, 4'd8, 4'd8, 1'b0);
        drive(4'h7, 4'h3, 4'd8, 4'd8, 1'b1);
        // Undefined code with branch high has no effect (R11).
        drive(4'hF, 4'h6, 4'd2, 4'd3, 1'b1);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule